// File: doc/BRIEF.md
# Settable Time-of-Day Counter

This block keeps the time of day as three binary fields: seconds, minutes and hours. In run mode it advances the time once for each rising edge of a slow external square wave, with the usual carries between fields. A level switch puts the block into setting mode. In that mode the square wave is ignored and three push-buttons adjust the fields, one button for each field.

Each button is first passed through a two-flop synchronizer. It is then filtered by a three-sample debouncer, which samples at a fixed, parameterized interval. Only a rising edge of the filtered level counts as a press. A press increments its own field by one and wraps that field without carrying into the next one. The square-wave input and the mode switch are synchronized in the same way. A status LED output follows the mode switch directly.

Top module: `tod_counter`

## Requirements
- R1: While rst_ni is low, sec_o, min_o and hr_o read 0. After reset the debouncer histories and edge trackers are clear.
- R2: In run mode (set_mode_i low), each rising edge of tick_i advances sec_o by exactly one. Holding tick_i high gives no further advance.
- R3: In run mode, seconds going from 59 to 0 advances minutes. Minutes going from 59 to 0 advances hours. Hours wrap from 23 to 0, so 23:59:59 plus one tick gives 00:00:00.
- R4: While set_mode_i is high, tick_i has no effect and the time holds.
- R5: In setting mode, a debounced press on btn_sec_i, btn_min_i or btn_hr_i increments only seconds, minutes or hours respectively. Seconds and minutes wrap 59 to 0 and hours wrap 23 to 0, with no carry into another field.
- R6: A button held high gives one increment only. It must drop low before it can give another.
- R7: The debouncer samples each synchronized button every SAMPLE_CYCLES clock cycles and reports high only when its last three samples are high. A pulse shorter than SAMPLE_CYCLES cycles gives no increment.
- R8: set_led_o equals set_mode_i at all times.
- R9: A button that is already high when setting mode is entered gives no increment until it has been released and pressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second square wave, asynchronous |
| set_mode_i | input | 1 | Mode switch: 1 = setting mode, 0 = run mode |
| btn_sec_i | input | 1 | Raw seconds adjust button |
| btn_min_i | input | 1 | Raw minutes adjust button |
| btn_hr_i | input | 1 | Raw hours adjust button |
| set_led_o | output | 1 | Status LED, mirrors set_mode_i |
| sec_o | output | 6 | Seconds, binary 0..59 |
| min_o | output | 6 | Minutes, binary 0..59 |
| hr_o | output | 5 | Hours, binary 0..23 |

## Verification
A wrong field state shows at once on sec_o, min_o or hr_o. Such an error persists, because nothing ever reloads the fields except reset. A carry or wrap error shows within one tick at the 59 and 23 boundaries. A stale edge tracker or a bad debounce history shows up differently: it appears as a missing, doubled or spurious increment, about three sample intervals after a button changes. The bench drives the fields to every wrap point through the buttons. It then counts the increments produced by held, short and pre-held buttons.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned SEC_W   = 6;
  localparam int unsigned MIN_W   = 6;
  localparam int unsigned HR_W    = 5;
  localparam int unsigned SEC_MAX = 59;
  localparam int unsigned MIN_MAX = 59;
  localparam int unsigned HR_MAX  = 23;
  localparam int unsigned NUM_BTN = 3;

  typedef enum int unsigned {
    F_SEC = 0,
    F_MIN = 1,
    F_HR  = 2
  } field_e;
endpackage

// File: rtl/tod_sync.sv
module tod_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tod_debounce.sv
module tod_debounce #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic raw_i,
  output logic level_o
);
  logic [DEPTH-1:0] hist_q;
  logic             level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      level_q <= 1'b0;
    end else if (strobe_i) begin
      hist_q  <= {hist_q[DEPTH-2:0], raw_i};
      level_q <= &{hist_q[DEPTH-2:0], raw_i};
    end
  end

  assign level_o = level_q;

  // R7: filtered level moves only on a sample strobe
  a_r7_level_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(level_o));
endmodule

// File: rtl/tod_field.sv
module tod_field #(
  parameter int unsigned WIDTH   = 6,
  parameter int unsigned MAX_VAL = 59
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [WIDTH-1:0] val_o,
  output logic             at_max_o
);
  localparam logic [WIDTH-1:0] MaxV = WIDTH'(MAX_VAL);

  logic [WIDTH-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (inc_i) val_q <= (val_q == MaxV) ? '0 : val_q + 1'b1;
  end

  assign val_o    = val_q;
  assign at_max_o = (val_q == MaxV);

  a_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_o <= MaxV);
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && at_max_o |=> val_o == '0);
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !at_max_o |=> val_o == $past(val_o) + 1'b1);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(val_o));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned SAMPLE_CYCLES = 2_500_000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DB_DEPTH      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             set_mode_i,
  input  logic             btn_sec_i,
  input  logic             btn_min_i,
  input  logic             btn_hr_i,
  output logic             set_led_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [MIN_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o
);
  localparam int unsigned CNT_W = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(SAMPLE_CYCLES - 1);
  localparam int unsigned SYNC_W = NUM_BTN + 2;

  logic [SYNC_W-1:0]  sync_s;
  logic               tick_s, mode_s;
  logic [NUM_BTN-1:0] btn_s, db, db_q, press;
  logic [CNT_W-1:0]   samp_cnt_q;
  logic               strobe;
  logic               tick_q, adv;
  logic               sec_max, min_max, hr_max;
  logic               sec_inc, min_inc, hr_inc;

  assign set_led_o = set_mode_i;

  tod_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({btn_hr_i, btn_min_i, btn_sec_i, set_mode_i, tick_i}),
    .q_o   (sync_s)
  );
  assign tick_s = sync_s[0];
  assign mode_s = sync_s[1];
  assign btn_s  = sync_s[SYNC_W-1:2];

  // one sample strobe shared by all debouncers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  samp_cnt_q <= '0;
    else if (samp_cnt_q == CntLast) samp_cnt_q <= '0;
    else                          samp_cnt_q <= samp_cnt_q + 1'b1;
  end
  assign strobe = (samp_cnt_q == CntLast);

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
    tod_debounce #(.DEPTH(DB_DEPTH)) u_db (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(strobe),
      .raw_i   (btn_s[g]),
      .level_o (db[g])
    );
  end

  // edge trackers run in both modes, so a button held on entry is not a press
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      db_q   <= db;
      tick_q <= tick_s;
    end
  end

  assign press = {NUM_BTN{mode_s}} & db & ~db_q;
  assign adv   = tick_s & ~tick_q & ~mode_s;

  assign sec_inc = adv | press[F_SEC];
  assign min_inc = (adv & sec_max) | press[F_MIN];
  assign hr_inc  = (adv & sec_max & min_max) | press[F_HR];

  tod_field #(.WIDTH(SEC_W), .MAX_VAL(SEC_MAX)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_inc), .val_o(sec_o), .at_max_o(sec_max));
  tod_field #(.WIDTH(MIN_W), .MAX_VAL(MIN_MAX)) u_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(min_inc), .val_o(min_o), .at_max_o(min_max));
  tod_field #(.WIDTH(HR_W), .MAX_VAL(HR_MAX)) u_hr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hr_inc), .val_o(hr_o), .at_max_o(hr_max));

  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_s && !press[F_SEC] |=> $stable(sec_o));
  a_r5_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_s && !press[F_MIN] |=> $stable(min_o));
  a_r6_one_per_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press[F_HR] |=> !press[F_HR]);
  a_r3_hour_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && sec_max && min_max && hr_max |=> hr_o == '0 && min_o == '0 && sec_o == '0);
endmodule

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  localparam int unsigned SC = 4;

  typedef struct packed {
    logic [1:0] op;   // 0 ticks, 1 sec press, 2 min press, 3 hr press
    logic [7:0] n;
    logic [4:0] h;
    logic [5:0] m;
    logic [5:0] s;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd5,  5'd0,  6'd0,  6'd5},
    '{2'd0, 8'd55, 5'd0,  6'd1,  6'd0},
    '{2'd1, 8'd59, 5'd0,  6'd1,  6'd59},
    '{2'd1, 8'd1,  5'd0,  6'd1,  6'd0},
    '{2'd2, 8'd58, 5'd0,  6'd59, 6'd0},
    '{2'd2, 8'd1,  5'd0,  6'd0,  6'd0},
    '{2'd3, 8'd23, 5'd23, 6'd0,  6'd0},
    '{2'd3, 8'd1,  5'd0,  6'd0,  6'd0},
    '{2'd3, 8'd23, 5'd23, 6'd0,  6'd0},
    '{2'd2, 8'd59, 5'd23, 6'd59, 6'd0},
    '{2'd1, 8'd59, 5'd23, 6'd59, 6'd59},
    '{2'd0, 8'd1,  5'd0,  6'd0,  6'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mode = 1'b0;
  logic [2:0] btn = '0;
  logic       led;
  logic [5:0] sec, mnt;
  logic [4:0] hr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tod_counter #(.SAMPLE_CYCLES(SC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .set_mode_i(mode),
    .btn_sec_i(btn[0]), .btn_min_i(btn[1]), .btn_hr_i(btn[2]),
    .set_led_o(led), .sec_o(sec), .min_o(mnt), .hr_o(hr));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_time(string req, int h, int m, int s);
    chk(req, {hr, mnt, sec}, {h[4:0], m[5:0], s[5:0]});
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_mode(logic v);
    mode = v;
    cyc(6);
  endtask

  task automatic do_tick();
    tick = 1'b1; cyc(5);
    tick = 1'b0; cyc(5);
  endtask

  task automatic do_press(int idx);
    btn[idx] = 1'b1; cyc(4 * SC + 8);
    btn[idx] = 1'b0; cyc(4 * SC + 8);
  endtask

  initial begin
    cyc(3);
    chk_time("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    cyc(3);
    chk_time("R1 after release", 0, 0, 0);
    chk("R8 led low", led, 0);
    mode = 1'b1; #1;
    chk("R8 led high", led, 1);
    go_mode(1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == 2'd0) begin
        go_mode(1'b0);
        for (int k = 0; k < VEC[i].n; k++) do_tick();
        chk_time($sformatf("R2 R3 vector %0d", i), VEC[i].h, VEC[i].m, VEC[i].s);
      end else begin
        go_mode(1'b1);
        for (int k = 0; k < VEC[i].n; k++) do_press(VEC[i].op - 1);
        chk_time($sformatf("R5 vector %0d", i), VEC[i].h, VEC[i].m, VEC[i].s);
      end
    end

    // R2: level held gives a single step
    go_mode(1'b0);
    tick = 1'b1; cyc(50); tick = 1'b0; cyc(5);
    chk_time("R2 held tick", 0, 0, 1);

    // R4: ticks ignored in setting mode
    go_mode(1'b1);
    for (int k = 0; k < 5; k++) do_tick();
    chk_time("R4 frozen", 0, 0, 1);

    // R6: long hold counts once
    btn[0] = 1'b1; cyc(150); btn[0] = 1'b0; cyc(30);
    chk_time("R6 long hold", 0, 0, 2);

    // R7: short glitch filtered
    btn[1] = 1'b1; cyc(SC - 1); btn[1] = 1'b0; cyc(40);
    chk_time("R7 glitch", 0, 0, 2);
    do_press(1);
    chk_time("R7 clean press", 0, 1, 2);

    // R9: button held across entry to setting mode
    go_mode(1'b0);
    btn[2] = 1'b1; cyc(30);
    go_mode(1'b1);
    cyc(40);
    chk_time("R9 held on entry", 0, 1, 2);
    btn[2] = 1'b0; cyc(30);
    do_press(2);
    chk_time("R9 press after release", 1, 1, 2);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    cyc(2);
    chk_time("R1 mid-run reset", 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule